// File: doc/BRIEF.md
# Command Stream Opcode Parser

This block sits behind a command fetch unit and turns a stream of 32-bit command words into register-write transactions for the units on the chip. Words arrive on a valid/ready input. The parser treats the first word as a header. The opcode in the header decides how many of the following words are payload and where each payload word goes. Every write leaves on a single registered output slot. It carries the current class id, a register offset, the data and full byte enables.

Set-class, incrementing, non-incrementing, masked and immediate headers produce writes directly. A restart header and a gather header do not write anything. Each raises a request that holds an address (and, for a gather, a count and a write mode) until the consumer accepts it. An unknown opcode stops the parser until reset.

Top module: `cmd_stream_parser`

## Requirements
- R1: The opcode is header bits [31:28]. A set-class header (opcode 0) loads the current class from bits [15:6]. Every later write carries that class until the next set-class header. Its 6-bit mask in bits [5:0] consumes payload words the same way a masked write does, based at offset bits [27:16] and written under the new class.
- R2: An incrementing write (opcode 1) with count N in bits [15:0] writes the next N words to offsets base, base+1, ... in order, where base is bits [27:16].
- R3: A non-incrementing write (opcode 2) with count N writes the next N words, all to the same offset from bits [27:16].
- R4: A masked write (opcode 3) with a 16-bit mask in bits [15:0] takes one payload word per set bit i, from lowest i to highest, and writes it to base+i.
- R5: An immediate write (opcode 4) consumes no payload. It writes bits [15:0] zero-extended to 32 bits to offset [27:16]. Every write has byte enables 4'hF.
- R6: A non-incrementing header with offset 0 and count 0 is a no-op. The word after it is parsed as a header.
- R7: A restart header (opcode 5) raises a restart request whose address is header bits [27:0] shifted left by 4. The request and its address stay unchanged until the request is accepted.
- R8: A gather header (opcode 6) takes the next word as a 32-bit fetch address. It then raises a gather request with count bits [13:0], write flag bit 15, incrementing flag bit 14 and offset bits [27:16]. The request is held unchanged until accepted.
- R9: Opcodes 7 to 15 set a sticky error flag. After that the input is never ready again until reset.
- R10: While a write is presented and not accepted, it stays unchanged and the input accepts no word. No word is lost or duplicated under back-pressure.
- R11: After reset no write or request is presented, the error flag is clear, the current class is 0 and the parser expects a header.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Command word present |
| in_data | input | 32 | Command word |
| in_ready | output | 1 | Parser takes the word this cycle |
| wr_valid | output | 1 | Register write presented |
| wr_ready | input | 1 | Register write accepted |
| wr_class | output | 10 | Class id of the write |
| wr_offset | output | 12 | Register offset of the write |
| wr_data | output | 32 | Write data |
| wr_be | output | 4 | Byte enables |
| jmp_valid | output | 1 | Restart request presented |
| jmp_ready | input | 1 | Restart request accepted |
| jmp_addr | output | 32 | Restart target address |
| gth_valid | output | 1 | Gather request presented |
| gth_ready | input | 1 | Gather request accepted |
| gth_addr | output | 32 | Gather fetch address |
| gth_count | output | 14 | Gather word count |
| gth_is_write | output | 1 | Gathered words are register writes |
| gth_incr | output | 1 | Gathered writes use incrementing offsets |
| gth_offset | output | 12 | Register offset for gathered writes |
| err | output | 1 | Sticky illegal-opcode flag |

## Verification
Two things can happen in the same cycle: the write slot drains to the consumer while a new payload word is taken into it. This is the streaming path that a burst or masked write uses. To provoke it, the bench drives the input back to back while a pseudo-random pattern toggles the write-ready line. Many cycles then see a handshake on both sides at once, and others see a stall. A scoreboard compares every write that leaves with the expected class, offset and data, in order. A final empty queue shows that no word was lost or written twice.

// File: rtl/cmdp_pkg.sv
// Shared widths and types for the command stream parser.
// Assumes 32-bit command words with the opcode in the top nibble.
package cmdp_pkg;
    localparam int WORD_W  = 32;
    localparam int CLASS_W = 10;
    localparam int OFF_W   = 12;
    localparam int CNT_W   = 16;
    localparam int GCNT_W  = 14;
    localparam int MASK_W  = 16;
    localparam int IDX_W   = $clog2(MASK_W);

    typedef enum logic [3:0] {
        OP_SETCLASS = 4'd0,
        OP_INCR     = 4'd1,
        OP_NONINCR  = 4'd2,
        OP_MASK     = 4'd3,
        OP_IMM      = 4'd4,
        OP_RESTART  = 4'd5,
        OP_GATHER   = 4'd6
    } opcode_e;

    typedef enum logic [1:0] {
        ST_HDR   = 2'd0,
        ST_BURST = 2'd1,
        ST_MASK  = 2'd2,
        ST_GADDR = 2'd3
    } pstate_e;
endpackage

// File: rtl/cmdp_hdr_decode.sv
// Header field splitter: purely combinational. It pulls every field
// that any opcode uses out of one header word. The consumer picks the
// fields that matter for the opcode it sees.
module cmdp_hdr_decode
    import cmdp_pkg::*;
(
    input  logic [WORD_W-1:0]  hdr,
    output logic [3:0]         opcode,
    output logic               legal,
    output logic [OFF_W-1:0]   offset,
    output logic [CLASS_W-1:0] class_id,
    output logic [MASK_W-1:0]  cls_mask,
    output logic [MASK_W-1:0]  low16,
    output logic [WORD_W-1:0]  jmp_target,
    output logic [GCNT_W-1:0]  g_count,
    output logic               g_write,
    output logic               g_incr
);
    // field extraction from fixed bit positions
    always_comb begin
        opcode     = hdr[31:28];
        legal      = (hdr[31:28] <= 4'd6);
        offset     = hdr[27:16];
        class_id   = hdr[15:6];
        cls_mask   = {{(MASK_W-6){1'b0}}, hdr[5:0]};
        low16      = hdr[15:0];
        jmp_target = {hdr[27:0], 4'b0000};
        g_count    = hdr[GCNT_W-1:0];
        g_write    = hdr[15];
        g_incr     = hdr[14];
    end
endmodule

// File: rtl/cmdp_mask_pick.sv
// Lowest-set-bit picker for masked writes. It gives the index of the
// lowest set bit, the mask with that bit cleared, and whether that was
// the last set bit. Assumes the mask is non-zero when it is used.
module cmdp_mask_pick
    import cmdp_pkg::*;
(
    input  logic [MASK_W-1:0] mask,
    output logic [IDX_W-1:0]  idx,
    output logic [MASK_W-1:0] rest,
    output logic              last
);
    logic [MASK_W-1:0] onehot;

    // isolate the lowest set bit and clear it in the remainder
    always_comb begin
        onehot = mask & (~mask + 1'b1);
        rest   = mask & (mask - 1'b1);
        last   = (rest == '0);
    end

    // encode the one-hot bit into its index
    always_comb begin
        idx = '0;
        for (int i = 0; i < MASK_W; i++)
            if (onehot[i]) idx = IDX_W'(i);
    end
endmodule

// File: rtl/cmdp_wr_slot.sv
// One-entry output register for register writes. It loads when asked
// and holds its contents until the consumer takes them. Assumes load is
// only asserted when the slot is empty or being drained this cycle.
module cmdp_wr_slot
    import cmdp_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic [CLASS_W-1:0] ld_class,
    input  logic [OFF_W-1:0]   ld_offset,
    input  logic [WORD_W-1:0]  ld_data,
    input  logic               ready,
    output logic               valid,
    output logic [CLASS_W-1:0] class_o,
    output logic [OFF_W-1:0]   offset_o,
    output logic [WORD_W-1:0]  data_o
);
    // valid flag: set on load, cleared once accepted
    always_ff @(posedge clk) begin
        if (!rst_n)        valid <= 1'b0;
        else if (load)     valid <= 1'b1;
        else if (ready)    valid <= 1'b0;
    end

    // payload registers: captured only on load
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            class_o  <= '0;
            offset_o <= '0;
            data_o   <= '0;
        end else if (load) begin
            class_o  <= ld_class;
            offset_o <= ld_offset;
            data_o   <= ld_data;
        end
    end
endmodule

// File: rtl/cmd_stream_parser.sv
// Command stream parser top. It decodes header words, sequences payload
// words into register writes, and raises restart and gather requests.
// Assumes one word per handshake. The input stalls while the write slot
// is full and undrained, while a request is pending, or after an error.
module cmd_stream_parser
    import cmdp_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic [WORD_W-1:0]  in_data,
    output logic               in_ready,
    output logic               wr_valid,
    input  logic               wr_ready,
    output logic [CLASS_W-1:0] wr_class,
    output logic [OFF_W-1:0]   wr_offset,
    output logic [WORD_W-1:0]  wr_data,
    output logic [3:0]         wr_be,
    output logic               jmp_valid,
    input  logic               jmp_ready,
    output logic [WORD_W-1:0]  jmp_addr,
    output logic               gth_valid,
    input  logic               gth_ready,
    output logic [WORD_W-1:0]  gth_addr,
    output logic [GCNT_W-1:0]  gth_count,
    output logic               gth_is_write,
    output logic               gth_incr,
    output logic [OFF_W-1:0]   gth_offset,
    output logic               err
);
    pstate_e            state_q;
    logic [CLASS_W-1:0] class_q;
    logic [OFF_W-1:0]   off_q;
    logic [CNT_W-1:0]   cnt_q;
    logic               incr_q;
    logic [MASK_W-1:0]  mask_q;

    logic [3:0]         d_op;
    logic               d_legal;
    logic [OFF_W-1:0]   d_off;
    logic [CLASS_W-1:0] d_class;
    logic [MASK_W-1:0]  d_cmask;
    logic [MASK_W-1:0]  d_low16;
    logic [WORD_W-1:0]  d_jmp;
    logic [GCNT_W-1:0]  d_gcnt;
    logic               d_gwr;
    logic               d_ginc;

    logic [IDX_W-1:0]   m_idx;
    logic [MASK_W-1:0]  m_rest;
    logic               m_last;

    logic               accept;
    logic               ld;
    logic [OFF_W-1:0]   ld_off;
    logic [WORD_W-1:0]  ld_data;

    cmdp_hdr_decode u_dec (
        .hdr(in_data), .opcode(d_op), .legal(d_legal), .offset(d_off),
        .class_id(d_class), .cls_mask(d_cmask), .low16(d_low16),
        .jmp_target(d_jmp), .g_count(d_gcnt), .g_write(d_gwr), .g_incr(d_ginc)
    );

    cmdp_mask_pick u_pick (
        .mask(mask_q), .idx(m_idx), .rest(m_rest), .last(m_last)
    );

    cmdp_wr_slot u_slot (
        .clk(clk), .rst_n(rst_n), .load(ld), .ld_class(class_q),
        .ld_offset(ld_off), .ld_data(ld_data), .ready(wr_ready),
        .valid(wr_valid), .class_o(wr_class), .offset_o(wr_offset),
        .data_o(wr_data)
    );

    assign wr_be = 4'hF;

    // input handshake: blocked by a full slot, a pending request or an error
    always_comb begin
        in_ready = !err && (!wr_valid || wr_ready) && !jmp_valid && !gth_valid;
        accept   = in_valid && in_ready;
    end

    // selects the write, if any, produced by the accepted word
    always_comb begin
        ld      = 1'b0;
        ld_off  = off_q;
        ld_data = in_data;
        if (accept) begin
            unique case (state_q)
                ST_HDR: if (d_op == OP_IMM) begin
                    ld      = 1'b1;
                    ld_off  = d_off;
                    ld_data = {{(WORD_W-MASK_W){1'b0}}, d_low16};
                end
                ST_BURST: ld = 1'b1;
                ST_MASK: begin
                    ld     = 1'b1;
                    ld_off = off_q + OFF_W'(m_idx);
                end
                default: ld = 1'b0;
            endcase
        end
    end

    // parser sequencing: header decode and payload accounting
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_HDR;
            class_q <= '0;
            off_q   <= '0;
            cnt_q   <= '0;
            incr_q  <= 1'b0;
            mask_q  <= '0;
            err     <= 1'b0;
        end else if (accept) begin
            unique case (state_q)
                ST_HDR: begin
                    off_q <= d_off;
                    if (!d_legal) err <= 1'b1;
                    unique case (d_op)
                        4'd0: begin
                            class_q <= d_class;
                            mask_q  <= d_cmask;
                            if (d_cmask != '0) state_q <= ST_MASK;
                        end
                        4'd1, 4'd2: begin
                            cnt_q  <= d_low16;
                            incr_q <= (d_op == OP_INCR);
                            if (d_low16 != '0) state_q <= ST_BURST;
                        end
                        4'd3: begin
                            mask_q <= d_low16;
                            if (d_low16 != '0) state_q <= ST_MASK;
                        end
                        4'd6:    state_q <= ST_GADDR;
                        default: state_q <= ST_HDR;
                    endcase
                end
                ST_BURST: begin
                    if (incr_q) off_q <= off_q + 1'b1;
                    cnt_q <= cnt_q - 1'b1;
                    if (cnt_q == CNT_W'(1)) state_q <= ST_HDR;
                end
                ST_MASK: begin
                    mask_q <= m_rest;
                    if (m_last) state_q <= ST_HDR;
                end
                ST_GADDR: state_q <= ST_HDR;
                default:  state_q <= ST_HDR;
            endcase
        end
    end

    // restart request: raised by its header, held until accepted
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            jmp_valid <= 1'b0;
            jmp_addr  <= '0;
        end else if (accept && state_q == ST_HDR && d_op == OP_RESTART) begin
            jmp_valid <= 1'b1;
            jmp_addr  <= d_jmp;
        end else if (jmp_ready) begin
            jmp_valid <= 1'b0;
        end
    end

    // gather request: header fields latched, raised on the address word
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gth_valid    <= 1'b0;
            gth_addr     <= '0;
            gth_count    <= '0;
            gth_is_write <= 1'b0;
            gth_incr     <= 1'b0;
            gth_offset   <= '0;
        end else if (accept && state_q == ST_HDR && d_op == OP_GATHER) begin
            gth_count    <= d_gcnt;
            gth_is_write <= d_gwr;
            gth_incr     <= d_ginc;
            gth_offset   <= d_off;
        end else if (accept && state_q == ST_GADDR) begin
            gth_valid <= 1'b1;
            gth_addr  <= in_data;
        end else if (gth_ready) begin
            gth_valid <= 1'b0;
        end
    end
endmodule

// File: rtl/cmdp_checker.sv
// Protocol checker for the command stream parser, bound to the top.
// Covers output hold under back-pressure, request hold and error stickiness.
module cmdp_checker
    import cmdp_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               in_ready,
    input logic               wr_valid,
    input logic               wr_ready,
    input logic [CLASS_W-1:0] wr_class,
    input logic [OFF_W-1:0]   wr_offset,
    input logic [WORD_W-1:0]  wr_data,
    input logic               jmp_valid,
    input logic               jmp_ready,
    input logic [WORD_W-1:0]  jmp_addr,
    input logic               gth_valid,
    input logic               gth_ready,
    input logic [WORD_W-1:0]  gth_addr,
    input logic [GCNT_W-1:0]  gth_count,
    input logic               err
);
    assert_wr_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_data)
                                     && $stable(wr_offset) && $stable(wr_class)));

    assert_no_take_when_full_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !wr_ready) |-> !in_ready);

    assert_jmp_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (jmp_valid && !jmp_ready) |=> (jmp_valid && $stable(jmp_addr)));

    assert_jmp_aligned_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(jmp_valid) |-> (jmp_addr[3:0] == 4'h0));

    assert_gth_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (gth_valid && !gth_ready) |=> (gth_valid && $stable(gth_addr)
                                       && $stable(gth_count)));

    assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> err);

    assert_err_blocks_R9: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> !in_ready);
endmodule

bind cmd_stream_parser cmdp_checker u_chk (
    .clk(clk), .rst_n(rst_n), .in_ready(in_ready),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_class(wr_class),
    .wr_offset(wr_offset), .wr_data(wr_data),
    .jmp_valid(jmp_valid), .jmp_ready(jmp_ready), .jmp_addr(jmp_addr),
    .gth_valid(gth_valid), .gth_ready(gth_ready), .gth_addr(gth_addr),
    .gth_count(gth_count), .err(err)
);

// File: tb/sim_cmd_stream_parser.sv
`timescale 1ns/1ps
module sim_cmd_stream_parser;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] in_data = '0;
    logic        in_ready;
    logic        wr_valid;
    logic        wr_ready = 1'b1;
    logic [9:0]  wr_class;
    logic [11:0] wr_offset;
    logic [31:0] wr_data;
    logic [3:0]  wr_be;
    logic        jmp_valid;
    logic        jmp_ready = 1'b0;
    logic [31:0] jmp_addr;
    logic        gth_valid;
    logic        gth_ready = 1'b0;
    logic [31:0] gth_addr;
    logic [13:0] gth_count;
    logic        gth_is_write;
    logic        gth_incr;
    logic [11:0] gth_offset;
    logic        err;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    logic        throttle = 1'b0;
    logic [15:0] lfsr = 16'hACE1;

    logic [53:0] exp_q[$];
    string       tag_q[$];

    always #2.5 clk = ~clk;

    cmd_stream_parser u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .in_ready(in_ready), .wr_valid(wr_valid), .wr_ready(wr_ready),
        .wr_class(wr_class), .wr_offset(wr_offset), .wr_data(wr_data),
        .wr_be(wr_be), .jmp_valid(jmp_valid), .jmp_ready(jmp_ready),
        .jmp_addr(jmp_addr), .gth_valid(gth_valid), .gth_ready(gth_ready),
        .gth_addr(gth_addr), .gth_count(gth_count), .gth_is_write(gth_is_write),
        .gth_incr(gth_incr), .gth_offset(gth_offset), .err(err)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic push(input string req, input logic [9:0] cls,
                        input logic [11:0] off, input logic [31:0] d);
        exp_q.push_back({cls, off, d});
        tag_q.push_back(req);
    endtask

    task automatic send(input logic [31:0] w);
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = w;
        #1;
        while (!in_ready) begin
            @(negedge clk);
            #1;
        end
        @(posedge clk);
    endtask

    task automatic idle();
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic drain(input string req);
        for (int i = 0; i < 2000 && exp_q.size() != 0; i++) @(negedge clk);
        check(req, 64'(exp_q.size()), 64'd0);
    endtask

    // scoreboard monitor: sets write-ready, then compares each handshake
    always @(negedge clk) begin
        wr_ready = throttle ? lfsr[0] : 1'b1;
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        #1;
        if (rst_n && wr_valid && wr_ready) begin
            if (exp_q.size() == 0) begin
                check("R10 unexpected write", {10'd0, wr_class, wr_offset, wr_data}, 64'hDEAD);
            end else begin
                string t;
                logic [53:0] e;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(t, {10'd0, wr_class, wr_offset, wr_data}, {10'd0, e});
                check("R5 byte enables", 64'(wr_be), 64'hF);
            end
        end
    end

    // watchdog: a hung run counts as a failure and still reports
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            fails++;
            $display("FAIL watchdog: actual %0d expected below 150000", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        check("R11 wr_valid", 64'(wr_valid), 0);
        check("R11 requests", {62'd0, jmp_valid, gth_valid}, 0);
        check("R11 err", 64'(err), 0);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check("R11 in_ready", 64'(in_ready), 1);

        // immediate write under reset class 0
        push("R5 R11 imm", 10'd0, 12'h012, 32'h0000BEEF);
        send({4'd4, 12'h012, 16'hBEEF});
        idle();
        drain("R5 imm drained");

        // set-class with mask 0b000101 at base 0x100
        push("R1 class mask bit0", 10'h2A5, 12'h100, 32'h11111111);
        push("R1 class mask bit2", 10'h2A5, 12'h102, 32'h22222222);
        push("R1 class held", 10'h2A5, 12'h055, 32'h00000007);
        send({4'd0, 12'h100, 10'h2A5, 6'b000101});
        send(32'h11111111);
        send(32'h22222222);
        send({4'd4, 12'h055, 16'h0007});
        idle();
        drain("R1 drained");

        // incrementing burst of 3, then non-incrementing burst of 4
        for (int i = 0; i < 3; i++) push("R2 incr", 10'h2A5, 12'h200 + 12'(i), 32'hA0 + 32'(i));
        for (int i = 0; i < 4; i++) push("R3 nonincr", 10'h2A5, 12'h030, 32'hB0 + 32'(i));
        send({4'd1, 12'h200, 16'd3});
        for (int i = 0; i < 3; i++) send(32'hA0 + 32'(i));
        send({4'd2, 12'h030, 16'd4});
        for (int i = 0; i < 4; i++) send(32'hB0 + 32'(i));
        idle();
        drain("R2 R3 drained");

        // masked write, bits 1, 4, 15
        push("R4 mask bit1", 10'h2A5, 12'h041, 32'hC1);
        push("R4 mask bit4", 10'h2A5, 12'h044, 32'hC4);
        push("R4 mask bit15", 10'h2A5, 12'h04F, 32'hCF);
        send({4'd3, 12'h040, 16'h8012});
        send(32'hC1);
        send(32'hC4);
        send(32'hCF);
        idle();
        drain("R4 drained");

        // no-op then an immediate that must be parsed as a header
        push("R6 header after nop", 10'h2A5, 12'h066, 32'h00001234);
        send(32'h2000_0000);
        send({4'd4, 12'h066, 16'h1234});
        idle();
        drain("R6 drained");

        // restart request held until accepted
        send({4'd5, 28'h0ABCDEF});
        idle();
        #1;
        check("R7 jmp_valid", 64'(jmp_valid), 1);
        check("R7 jmp_addr", 64'(jmp_addr), 64'h0ABCDEF0);
        repeat (3) @(negedge clk);
        #1;
        check("R7 held", {31'd0, jmp_valid, jmp_addr}, {31'd0, 1'b1, 32'h0ABCDEF0});
        check("R7 input stalled", 64'(in_ready), 0);
        jmp_ready = 1'b1;
        @(negedge clk);
        jmp_ready = 1'b0;
        #1;
        check("R7 released", 64'(jmp_valid), 0);

        // gather with write, incrementing, offset 0x077, count 0x2345
        send({4'd6, 12'h077, 1'b1, 1'b1, 14'h2345});
        send(32'h8000_1000);
        idle();
        #1;
        check("R8 gth_valid", 64'(gth_valid), 1);
        check("R8 gth_addr", 64'(gth_addr), 64'h80001000);
        check("R8 fields", {34'd0, gth_count, gth_is_write, gth_incr, gth_offset},
              {34'd0, 14'h2345, 1'b1, 1'b1, 12'h077});
        repeat (2) @(negedge clk);
        #1;
        check("R8 held", 64'(gth_valid), 1);
        gth_ready = 1'b1;
        @(negedge clk);
        gth_ready = 1'b0;
        #1;
        check("R8 released", 64'(gth_valid), 0);

        // throttled streaming: long bursts under random write-ready
        throttle = 1'b1;
        for (int i = 0; i < 40; i++) push("R10 incr stream", 10'h2A5, 12'h300 + 12'(i), 32'h5000 + 32'(i));
        for (int i = 0; i < 5; i++) push("R10 mask stream", 10'h2A5, 12'h400 + 12'(3 * i), 32'h6000 + 32'(i));
        send({4'd1, 12'h300, 16'd40});
        for (int i = 0; i < 40; i++) send(32'h5000 + 32'(i));
        send({4'd3, 12'h400, 16'b0001_0010_0100_1001});
        for (int i = 0; i < 5; i++) send(32'h6000 + 32'(i));
        idle();
        drain("R10 no loss");
        throttle = 1'b0;

        // illegal opcode: sticky error and input stop
        send(32'h7000_0000);
        idle();
        #1;
        check("R9 err set", 64'(err), 1);
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = {4'd4, 12'h001, 16'h0001};
        repeat (4) @(negedge clk);
        #1;
        check("R9 input stopped", {62'd0, in_ready, err}, {62'd0, 1'b0, 1'b1});
        check("R9 no write", 64'(wr_valid), 0);
        in_valid = 1'b0;
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        #1;
        check("R11 err cleared", {62'd0, err, in_ready}, {62'd0, 1'b0, 1'b1});

        // class returns to 0 after reset
        push("R11 class reset", 10'd0, 12'h009, 32'h00000009);
        send({4'd4, 12'h009, 16'h0009});
        idle();
        drain("R11 drained");

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule